// File: doc/BRIEF.md
# Partial Timestamp Reconstruction Unit

A time-stamping port often keeps only the low bits of a free-running 64-bit time counter when a frame enters or leaves. This unit rebuilds the full 64-bit value from such a truncated stamp. It takes a full read of the counter made after the capture and assumes that at most one wraparound of the low field has happened since then. The stamp width `STAMP_W` is a parameter, set to 24 or 32. Each reconstruction request gives a registered 64-bit result one cycle later.

The unit also holds an egress stamp register. Each new egress capture loads it with the partial stamp and sets an update flag. A software read clears the flag. The register is presented as a 64-bit payload. The flag is always bit 0. The stamp field moves with the width: a 24-bit stamp sits in bits 31:8 of the low word, and a 32-bit stamp fills the entire upper word.

Top module: `ts_recover_unit`

## Requirements
- R1: After a synchronous active-low reset, `result_valid_o` is 0, `result_o` is 0 and `egr_word_o` is 0.
- R2: `result_valid_o` is 1 in exactly the cycle after a cycle in which `req_valid_i` was 1, and 0 otherwise.
- R3: A valid result carries the requested partial stamp unchanged in its low `STAMP_W` bits.
- R4: If the low `STAMP_W` bits of `now_i` are strictly greater than the stamp, the bits of the result above `STAMP_W` equal those of `now_i`.
- R5: If the low `STAMP_W` bits of `now_i` are less than or equal to the stamp (equality counts as a wrap), the result is the candidate minus 2^`STAMP_W`, computed modulo 2^64.
- R6: In a cycle without a request, `result_o` keeps its previous value.
- R7: An egress capture (`cap_valid_i`=1) sets bit 0 of `egr_word_o` on the next cycle. The stamp is placed at bits 31:8 for `STAMP_W`=24 or at bits 63:32 for `STAMP_W`=32. All other bits are 0.
- R8: A read pulse (`rd_i`=1) without a capture clears bit 0 on the next cycle and leaves the stamp field as it was.
- R9: When a capture and a read fall in the same cycle, the capture wins: the flag is 1 and the new stamp is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_i | input | 64 | Full time counter read after the capture |
| stamp_i | input | STAMP_W | Partial stamp to reconstruct |
| req_valid_i | input | 1 | Reconstruction request |
| result_valid_o | output | 1 | Result is valid |
| result_o | output | 64 | Reconstructed 64-bit stamp |
| cap_valid_i | input | 1 | New egress stamp captured |
| cap_stamp_i | input | STAMP_W | Captured egress partial stamp |
| rd_i | input | 1 | Software read of the egress register |
| egr_word_o | output | 64 | Egress register payload: flag at bit 0, stamp field depends on width |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle request-to-result timing and that the low field of each result equals the stamp requested. It checks that the result holds between requests. It also checks how the update flag answers captures and reads. Whether a wrap was detected, including the equal-bits case, shows only in the upper bits. The bench therefore checks those against hand-computed values for both widths, together with the exact layout of the egress payload.

// File: rtl/ts_recover_pkg.sv
// Shared constants for the partial timestamp reconstruction unit.
// Assumes a 64-bit free-running time counter.
package ts_recover_pkg;
    localparam int TIME_W = 64;
    typedef logic [TIME_W-1:0] time_word_t;
endpackage

// File: rtl/ts_wrap_fix.sv
// Combinational wrap correction: joins the upper bits of the current time
// with the partial stamp, then steps back one wrap period when the low bits
// of the current time are not above the stamp (equal counts as a wrap).
// Assumes reconstruction happens within one wrap period of the capture.
module ts_wrap_fix
    import ts_recover_pkg::*;
#(
    parameter int STAMP_W = 24
) (
    input  time_word_t         now_i,
    input  logic [STAMP_W-1:0] stamp_i,
    output time_word_t         full_o
);
    localparam time_word_t WRAP_STEP = time_word_t'(1) << STAMP_W;

    time_word_t candidate;
    logic       wrapped;

    // Build the candidate and subtract one wrap when needed
    always_comb begin
        candidate = {now_i[TIME_W-1:STAMP_W], stamp_i};
        wrapped   = (now_i[STAMP_W-1:0] <= stamp_i);
        full_o    = wrapped ? (candidate - WRAP_STEP) : candidate;
    end
endmodule

// File: rtl/ts_result_reg.sv
// Result stage: registers a corrected stamp on each request and raises a
// valid flag for exactly one cycle; the value holds between requests.
module ts_result_reg
    import ts_recover_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  time_word_t value_i,
    output logic       valid_o,
    output time_word_t value_o
);
    // Pipeline register with hold when no request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            value_o <= '0;
        end else begin
            valid_o <= load_i;
            if (load_i) value_o <= value_i;
        end
    end
endmodule

// File: rtl/ts_egress_reg.sv
// Egress stamp register: holds the last captured partial stamp and an
// update flag. A capture sets the flag, a read clears it, and a capture
// wins over a read in the same cycle. The payload layout depends on the
// stamp width: narrow stamps are left-aligned in the low word, 32-bit
// stamps fill the upper word. Flag is always bit 0.
module ts_egress_reg
    import ts_recover_pkg::*;
#(
    parameter int STAMP_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_valid_i,
    input  logic [STAMP_W-1:0] cap_stamp_i,
    input  logic               rd_i,
    output time_word_t         word_o
);
    logic               upd_flag;
    logic [STAMP_W-1:0] held_stamp;

    // Flag and stamp storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_flag   <= 1'b0;
            held_stamp <= '0;
        end else if (cap_valid_i) begin
            upd_flag   <= 1'b1;
            held_stamp <= cap_stamp_i;
        end else if (rd_i) begin
            upd_flag   <= 1'b0;
        end
    end

    // Payload layout picked by the stamp width
    generate
        if (STAMP_W >= 32) begin : g_wide
            always_comb begin
                word_o         = '0;
                word_o[63:32]  = held_stamp[31:0];
                word_o[0]      = upd_flag;
            end
        end else begin : g_narrow
            always_comb begin
                word_o                  = '0;
                word_o[31:32-STAMP_W]   = held_stamp;
                word_o[0]               = upd_flag;
            end
        end
    endgenerate
endmodule

// File: rtl/ts_recover_unit.sv
// Partial timestamp reconstruction unit (top). Rebuilds a 64-bit stamp
// from its low STAMP_W bits and a later full counter read, with one cycle
// of latency, and holds the egress stamp register. STAMP_W is 24 or 32.
module ts_recover_unit
    import ts_recover_pkg::*;
#(
    parameter int STAMP_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        now_i,
    input  logic [STAMP_W-1:0] stamp_i,
    input  logic               req_valid_i,
    output logic               result_valid_o,
    output logic [63:0]        result_o,
    input  logic               cap_valid_i,
    input  logic [STAMP_W-1:0] cap_stamp_i,
    input  logic               rd_i,
    output logic [63:0]        egr_word_o
);
    time_word_t fixed;

    ts_wrap_fix #(.STAMP_W(STAMP_W)) fix_i (
        .now_i   (now_i),
        .stamp_i (stamp_i),
        .full_o  (fixed)
    );

    ts_result_reg res_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (req_valid_i),
        .value_i (fixed),
        .valid_o (result_valid_o),
        .value_o (result_o)
    );

    ts_egress_reg #(.STAMP_W(STAMP_W)) egr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_valid_i (cap_valid_i),
        .cap_stamp_i (cap_stamp_i),
        .rd_i        (rd_i),
        .word_o      (egr_word_o)
    );
endmodule

// File: rtl/ts_recover_chk.sv
// Checker for ts_recover_unit: timing, low-field and flag properties.
module ts_recover_chk #(
    parameter int STAMP_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STAMP_W-1:0] stamp_i,
    input logic               req_valid_i,
    input logic               result_valid_o,
    input logic [63:0]        result_o,
    input logic               cap_valid_i,
    input logic               rd_i,
    input logic [63:0]        egr_word_o
);
    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> result_valid_o);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !result_valid_o);

    assert_low_field_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (result_o[STAMP_W-1:0] == $past(stamp_i)));

    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> $stable(result_o));

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_i |=> egr_word_o[0]);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !cap_valid_i) |=> !egr_word_o[0]);
endmodule

bind ts_recover_unit ts_recover_chk #(.STAMP_W(STAMP_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .stamp_i        (stamp_i),
    .req_valid_i    (req_valid_i),
    .result_valid_o (result_valid_o),
    .result_o       (result_o),
    .cap_valid_i    (cap_valid_i),
    .rd_i           (rd_i),
    .egr_word_o     (egr_word_o)
);

// File: tb/ts_recover_unit_tb.sv
// Directed bench: a 24-bit instance (dut_i) and a 32-bit instance.
module ts_recover_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now_i = '0;
    logic        req_valid_i = 1'b0;
    logic [23:0] s24 = '0, c24 = '0;
    logic [31:0] s32 = '0, c32 = '0;
    logic        cap24 = 1'b0, cap32 = 1'b0, rd24 = 1'b0, rd32 = 1'b0;
    logic        v24, v32;
    logic [63:0] r24, r32, e24, e32;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ts_recover_unit #(.STAMP_W(24)) dut_i (
        .clk(clk), .rst_n(rst_n), .now_i(now_i), .stamp_i(s24),
        .req_valid_i(req_valid_i), .result_valid_o(v24), .result_o(r24),
        .cap_valid_i(cap24), .cap_stamp_i(c24), .rd_i(rd24), .egr_word_o(e24));

    ts_recover_unit #(.STAMP_W(32)) dut_w32_i (
        .clk(clk), .rst_n(rst_n), .now_i(now_i), .stamp_i(s32),
        .req_valid_i(req_valid_i), .result_valid_o(v32), .result_o(r32),
        .cap_valid_i(cap32), .cap_stamp_i(c32), .rd_i(rd32), .egr_word_o(e32));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset state of both instances
    task automatic t_reset();
        chk("R1 valid24", 64'(v24), 64'd0);
        chk("R1 result24", r24, 64'd0);
        chk("R1 egr24", e24, 64'd0);
        chk("R1 egr32", e32, 64'd0);
    endtask

    // One request, check result one cycle later, then the hold cycle
    task automatic t_recon(input logic [63:0] now, input logic [23:0] a, input logic [31:0] b,
                           input logic [63:0] x24, input logic [63:0] x32, input string tag);
        now_i = now; s24 = a; s32 = b; req_valid_i = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid_i = 1'b0;
        chk({tag, " R2 valid"}, 64'(v24 & v32), 64'd1);
        chk({tag, " R3 r24"}, r24, x24);
        chk({tag, " r32"}, r32, x32);
        now_i = ~now; s24 = ~a; s32 = ~b;
        @(posedge clk); @(negedge clk);
        chk({tag, " R2 idle"}, 64'(v24 | v32), 64'd0);
        chk({tag, " R6 hold24"}, r24, x24);
        chk({tag, " R6 hold32"}, r32, x32);
    endtask

    // Egress register capture, read and collision
    task automatic t_egress();
        c24 = 24'hABCDEF; c32 = 32'h1234_5678; cap24 = 1; cap32 = 1;
        @(posedge clk); @(negedge clk);
        cap24 = 0; cap32 = 0;
        chk("R7 layout24", e24, 64'h0000_0000_ABCD_EF01);
        chk("R7 layout32", e32, 64'h1234_5678_0000_0001);
        rd24 = 1; rd32 = 1;
        @(posedge clk); @(negedge clk);
        rd24 = 0; rd32 = 0;
        chk("R8 clear24", e24, 64'h0000_0000_ABCD_EF00);
        chk("R8 clear32", e32, 64'h1234_5678_0000_0000);
        c24 = 24'h00_0102; c32 = 32'hFEDC_0001; cap24 = 1; cap32 = 1; rd24 = 1; rd32 = 1;
        @(posedge clk); @(negedge clk);
        cap24 = 0; cap32 = 0; rd24 = 0; rd32 = 0;
        chk("R9 both24", e24, 64'h0000_0000_0001_0201);
        chk("R9 both32", e32, 64'hFEDC_0001_0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R4: no wrap (now low above stamp)
        t_recon(64'h0000_0001_2345_6789, 24'h000100, 32'h0000_0008,
                64'h0000_0001_2300_0100, 64'h0000_0001_0000_0008, "R4 nowrap");
        // R5: equal low bits count as a wrap
        t_recon(64'h0000_0001_2345_6789, 24'h456789, 32'h2345_6789,
                64'h0000_0001_2245_6789, 64'h0000_0000_2345_6789, "R5 equal");
        // R5: stamp above now low bits
        t_recon(64'h0000_0005_0000_0010, 24'hFFFFFF, 32'hFFFF_FFF0,
                64'h0000_0004_FFFF_FFFF, 64'h0000_0004_FFFF_FFF0, "R5 wrap");
        // R5: wrap below zero wraps modulo 2^64
        t_recon(64'h0000_0000_0000_0000, 24'h000000, 32'h0000_0000,
                64'hFFFF_FFFF_FF00_0000, 64'hFFFF_FFFF_0000_0000, "R5 modulo");
        t_egress();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule